// File: doc/BRIEF.md
# Four-Channel Dual-Reload PWM Timer Bank

This block holds a bank of independent down-counting channels on a small word-addressed register bus. Each channel has two reload values: one sets how long the low phase lasts and the other how long the high phase lasts. A channel runs in one of two modes. In PWM mode the output alternates between the two phases. In periodic-timer mode only the low reload value is used, and the output toggles once per period.

Every terminal count raises a pending flag for that channel. The channel drives its own interrupt line while the flag is pending and its mask is clear. All channel lines are also ORed onto a combined line and collected in a read-only status word. Software acknowledges a channel's interrupt by reading that channel's acknowledge word. The reload and control words read back exactly what was last written, so software can save a channel's whole setup and restore it later.

The bus is word-addressed. Each channel occupies four consecutive words starting at channel×4. Offset 0 is the low reload, offset 1 the high reload, offset 2 the control word and offset 3 the acknowledge word. The status word sits at address NCH×4.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads zero, and all PWM outputs, channel interrupt lines and the combined line are low.
- R2: The low reload and high reload words read back the last written value truncated to CW bits. The control word reads back its three bits, and all other read bits are zero. Control bit 0 selects PWM mode (1) or timer mode (0), bit 1 is the run enable and bit 2 is the interrupt mask.
- R3: In PWM mode the output is low for L+1 cycles starting with the cycle after the enabling write, then high for H+1 cycles, and then keeps alternating. L is the low reload value and H the high reload value.
- R4: In timer mode the counter reloads only from the low reload value, and the output toggles every L+1 cycles, starting low. This holds up to the largest reload value of CW bits.
- R5: Each terminal count sets the channel's pending flag. The flag shows on the channel's interrupt line in the cycle after the terminal count and on bit n of the status word for channel n.
- R6: A read of a channel's acknowledge word returns the channel's interrupt state in bit 0 and clears its pending flag. Reads of other words and writes to the acknowledge address leave the flag unchanged. If a terminal count occurs in the same cycle as the acknowledge read, the flag stays set.
- R7: While the mask bit is set, the channel's interrupt line and its status bit stay low. The flag is still kept, so clearing the mask exposes any terminal count that has already occurred.
- R8: Writing the control word with the enable bit clear stops the counter and forces the output low in the next cycle. The pending flag is kept. The next enable starts again from a full low phase.
- R9: Channels run independently of each other, and the combined line is the OR of all channel interrupt lines.
- R10: A reload value written while the channel is running takes effect at the next reload. The phase already in progress is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DW | Read data, valid while bus_rd is high |
| pwm_o | output | NCH | Per-channel PWM or timer output |
| irq_o | output | NCH | Per-channel interrupt lines |
| irq_any_o | output | 1 | OR of all channel interrupt lines |

## Verification
The bench builds the bank with four channels and an 8-bit counter (CW=8). The narrow counter lets a single run reach the largest reload value of 255, where a 256-cycle phase is checked exactly, and it also exercises truncation on readback. Four channels allow two channels to run with unrelated periods at the same time while others stay masked or stopped. The combined line and the status word can then be checked with several sources active.

// File: rtl/pwmbank_pkg.sv
package pwmbank_pkg;
    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTRL = 2'd2,
        REG_ACK  = 2'd3
    } reg_sel_e;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_EN_BIT   = 1;
    localparam int CTRL_MASK_BIT = 2;
    localparam int CTRL_W        = 3;
    localparam int WORDS_PER_CH  = 4;
endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
    import pwmbank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 5
) (
    input  logic [AW-1:0]  addr,
    input  logic           wr,
    input  logic           rd,
    output logic [NCH-1:0] ch_hit,
    output logic [NCH-1:0] ch_wr,
    output logic [NCH-1:0] ch_ack,
    output logic [1:0]     reg_sel,
    output logic           status_hit
);
    localparam int CHW = AW - 2;

    logic [CHW-1:0] ch_field;
    logic           in_bank;

    assign ch_field   = addr[AW-1:2];
    assign reg_sel    = addr[1:0];
    assign in_bank    = (addr < AW'(NCH * WORDS_PER_CH));
    assign status_hit = (addr == AW'(NCH * WORDS_PER_CH));

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign ch_hit[g] = in_bank && (ch_field == CHW'(g));
        assign ch_wr[g]  = wr && ch_hit[g];
        assign ch_ack[g] = rd && ch_hit[g] && (reg_sel == REG_ACK);
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwmbank_pkg::*;
#(
    parameter int CW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    reg_sel,
    input  logic [CW-1:0] wdata,
    input  logic          ack_rd,
    output logic [DW-1:0] rd_word,
    output logic          pwm_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
        logic          mode_pwm;
        logic          en;
        logic          mask;
        logic [CW-1:0] cnt;
        logic          run;
        logic          phase_hi;
        logic          out;
        logic          pend;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     tc;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (reg_sel)
                REG_LO:   s_d.lo = wdata;
                REG_HI:   s_d.hi = wdata;
                REG_CTRL: begin
                    s_d.mode_pwm = wdata[CTRL_MODE_BIT];
                    s_d.en       = wdata[CTRL_EN_BIT];
                    s_d.mask     = wdata[CTRL_MASK_BIT];
                end
                default: ;
            endcase
        end

        tc = s_q.run && s_d.en && (s_q.cnt == '0);

        if (!s_d.en) begin
            s_d.run      = 1'b0;
            s_d.cnt      = '0;
            s_d.phase_hi = 1'b0;
            s_d.out      = 1'b0;
        end else if (!s_q.run) begin
            s_d.run      = 1'b1;
            s_d.cnt      = s_d.lo;
            s_d.phase_hi = 1'b0;
            s_d.out      = 1'b0;
        end else if (tc) begin
            if (s_d.mode_pwm && !s_q.phase_hi) begin
                s_d.cnt      = s_d.hi;
                s_d.phase_hi = 1'b1;
                s_d.out      = 1'b1;
            end else if (s_d.mode_pwm) begin
                s_d.cnt      = s_d.lo;
                s_d.phase_hi = 1'b0;
                s_d.out      = 1'b0;
            end else begin
                s_d.cnt      = s_d.lo;
                s_d.phase_hi = 1'b0;
                s_d.out      = ~s_q.out;
            end
        end else begin
            s_d.cnt = s_q.cnt - CW'(1);
        end

        if (ack_rd) s_d.pend = 1'b0;
        if (tc)     s_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o = s_q.out;
    assign irq_o = s_q.pend && !s_q.mask;

    always_comb begin
        case (reg_sel)
            REG_LO:   rd_word = DW'(s_q.lo);
            REG_HI:   rd_word = DW'(s_q.hi);
            REG_CTRL: rd_word = DW'({s_q.mask, s_q.en, s_q.mode_pwm});
            default:  rd_word = DW'(irq_o);
        endcase
    end

    // R3 / R4: output holds while the counter is between terminal counts
    a_r3_hold_mid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.cnt != '0 && !wr_en) |=> $stable(pwm_o));

    // R3 / R4: every terminal count flips the output
    a_r4_tc_flips_output: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.cnt == '0 && !wr_en) |=> (pwm_o != $past(pwm_o)));

    // R5: terminal count leaves the flag pending
    a_r5_tc_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.cnt == '0 && !wr_en) |=> s_q.pend);

    // R6: an acknowledge read without a terminal count clears the flag
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !(s_q.run && s_q.cnt == '0)) |=> !s_q.pend);

    // R8: a control write with enable clear stops the channel, output low
    a_r8_stop_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == REG_CTRL && !wdata[CTRL_EN_BIT]) |=> (!pwm_o && !s_q.run));
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwmbank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int DW  = 32,
    localparam int AW = $clog2(NCH * WORDS_PER_CH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_rd,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_o,
    output logic [NCH-1:0] irq_o,
    output logic           irq_any_o
);
    logic [NCH-1:0] ch_hit, ch_wr, ch_ack;
    logic [1:0]     reg_sel;
    logic           status_hit;
    logic [DW-1:0]  words [NCH];

    pwm_bus_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .addr       (bus_addr),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .ch_hit     (ch_hit),
        .ch_wr      (ch_wr),
        .ch_ack     (ch_ack),
        .reg_sel    (reg_sel),
        .status_hit (status_hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan #(.CW(CW), .DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_wr[g]),
            .reg_sel (reg_sel),
            .wdata   (bus_wdata[CW-1:0]),
            .ack_rd  (ch_ack[g]),
            .rd_word (words[g]),
            .pwm_o   (pwm_o[g]),
            .irq_o   (irq_o[g])
        );
    end

    assign irq_any_o = |irq_o;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (status_hit) bus_rdata = DW'(irq_o);
            for (int i = 0; i < NCH; i++) begin
                if (ch_hit[i]) bus_rdata = words[i];
            end
        end
    end

    // R9: the combined line is high exactly when some channel line is high
    a_r9_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any_o == ($countones(irq_o) != 0));

    // R6: at most one channel is acknowledged by one read
    a_r6_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ack));
endmodule

// File: tb/tb_pwm_timer_bank.sv
`timescale 1ns/1ps
module tb_pwm_timer_bank;
    localparam int NCH = 4;
    localparam int CW  = 8;
    localparam int DW  = 32;
    localparam int AW  = 5;
    localparam int ST  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [DW-1:0]  bus_wdata = '0;
    logic           bus_rd = 1'b0;
    logic [DW-1:0]  bus_rdata;
    logic [NCH-1:0] pwm_o, irq_o;
    logic           irq_any_o;

    int tests = 0;
    int fails = 0;

    pwm_timer_bank #(.NCH(NCH), .CW(CW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pwm_o(pwm_o), .irq_o(irq_o), .irq_any_o(irq_any_o));

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic pwm_exp(input int k, input int l, input int h);
        return (k % (l + h + 2)) > l;
    endfunction

    task automatic quiesce();
        logic [31:0] d;
        for (int c = 0; c < NCH; c++) begin
            wr(c*4 + 2, 0);
            rd(c*4 + 3, d);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pwm_o", pwm_o, 0);
        chk("R1 irq_o", irq_o, 0);
        chk("R1 irq_any", irq_any_o, 0);
        for (int a = 0; a <= ST; a++) begin
            rd(a, d);
            chk($sformatf("R1 reg %0d", a), d, 0);
        end
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(4, 32'hA5);         rd(4, d); chk("R2 low reload", d, 32'hA5);
        wr(4, 32'h1FF);        rd(4, d); chk("R2 low truncated", d, 32'hFF);
        wr(5, 32'h3C);         rd(5, d); chk("R2 high reload", d, 32'h3C);
        wr(6, 32'hFFFF_FFF5);  rd(6, d); chk("R2 control", d, 32'h5);
        chk("R2 stopped output", pwm_o[1], 0);
        wr(6, 0);
    endtask

    task automatic t_pwm();
        logic [31:0] d;
        int errs = 0;
        wr(0, 2); wr(1, 1);
        wr(2, 3);
        for (int k = 0; k < 20; k++) begin
            if (k > 0) @(negedge clk);
            if (pwm_o[0] !== pwm_exp(k, 2, 1)) errs++;
            if (irq_o[0] !== (k >= 3)) errs++;
        end
        chk("R3 pwm waveform mismatches", errs, 0);
        chk("R9 combined line", irq_any_o, 1);
        rd(ST, d);
        chk("R5 status bit0", d[3:0], 4'b0001);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        wr(2, 0);
        chk("R8 output low after stop", pwm_o[0], 0);
        rd(ST, d); chk("R8 pending kept after stop", d[0], 1);
        rd(0, d);  rd(ST, d); chk("R6 other read keeps flag", d[0], 1);
        wr(3, 32'hFFFF_FFFF); rd(ST, d); chk("R6 write to ack keeps flag", d[0], 1);
        rd(3, d);  chk("R6 ack read value", d, 1);
        chk("R6 line cleared", irq_o[0], 0);
        rd(ST, d); chk("R6 status cleared", d[3:0], 0);
    endtask

    task automatic t_timer();
        int errs = 0;
        wr(4, 3); wr(5, 0);
        wr(6, 2);
        for (int k = 0; k < 24; k++) begin
            if (k > 0) @(negedge clk);
            if (pwm_o[1] !== logic'((k / 4) % 2)) errs++;
        end
        chk("R4 timer toggles every L+1", errs, 0);
        quiesce();
    endtask

    task automatic t_timer_max();
        wr(4, 255);
        wr(6, 2);
        for (int k = 1; k <= 255; k++) @(negedge clk);
        chk("R4 max reload still low at 255", pwm_o[1], 0);
        @(negedge clk);
        chk("R4 max reload toggles at 256", pwm_o[1], 1);
        quiesce();
    endtask

    task automatic t_mask();
        logic [31:0] d;
        int errs = 0;
        wr(8, 1); wr(9, 1);
        wr(10, 7);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (irq_o[2] !== 1'b0 || irq_any_o !== 1'b0) errs++;
        end
        chk("R7 masked lines low", errs, 0);
        rd(ST, d); chk("R7 masked status", d[3:0], 0);
        wr(10, 3);
        chk("R7 unmask exposes flag", irq_o[2], 1);
        chk("R9 combined follows unmasked", irq_any_o, 1);
        quiesce();
    endtask

    task automatic t_restart();
        int errs = 0;
        wr(12, 4); wr(13, 2);
        wr(14, 3);
        for (int k = 1; k <= 6; k++) @(negedge clk);
        chk("R3 mid high phase", pwm_o[3], 1);
        wr(14, 1);
        chk("R8 stop forces low", pwm_o[3], 0);
        wr(14, 3);
        for (int k = 0; k < 14; k++) begin
            if (k > 0) @(negedge clk);
            if (pwm_o[3] !== pwm_exp(k, 4, 2)) errs++;
        end
        chk("R8 restart from full low phase", errs, 0);
        quiesce();
    endtask

    task automatic t_indep();
        int errs = 0;
        wr(0, 1); wr(1, 1);
        wr(12, 2); wr(13, 2);
        wr(2, 3);
        wr(14, 3);
        for (int k = 2; k < 30; k++) begin
            if (k > 2) @(negedge clk);
            if (pwm_o[0] !== pwm_exp(k, 1, 1)) errs++;
            if (pwm_o[3] !== pwm_exp(k - 2, 2, 2)) errs++;
        end
        chk("R9 two channels independent", errs, 0);
        quiesce();
    endtask

    task automatic t_reload_live();
        int errs = 0;
        wr(4, 5);
        wr(6, 2);
        wr(4, 1);
        for (int k = 2; k < 14; k++) begin
            if (k > 2) @(negedge clk);
            if (pwm_o[1] !== ((k < 6) ? 1'b0 : logic'(((k - 6) / 2) % 2 == 0))) errs++;
        end
        chk("R10 new reload at next load", errs, 0);
        quiesce();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_pwm();
        t_ack();
        t_timer();
        t_timer_max();
        t_mask();
        t_restart();
        t_indep();
        t_reload_live();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule